// File: doc/BRIEF.md
# Flash Command Sequencer with Suspend

This block is the mode controller of a four-plane flash array, placed behind a bus decoder that hands it single-cycle write and read events. Unlock sequences of fixed address/data pairs open a word program or a sector erase. A countdown timer then runs the operation while the array keeps serving reads in every plane except the busy one. Software learns that an operation has finished by reading the busy plane: bit 7 shows the inverse of the target value and bit 6 flips on every such read. The sequencer drives a small word array of its own and applies each program or erase to that array when the timer expires.

A running program or erase can be put on hold with a suspend code for as long as needed and restarted with a resume code. While an operation is on hold, one program to a different sector may run. A two-bit supply-level input gates all of this. At the inhibit level, program and erase requests are dropped. At the high level, both timers are shortened, and a six-write entry code switches the block into single-pulse program mode. In that mode every write programs its data directly, including writes whose data looks like a command. The mode ends only on reset or when the supply level leaves high. The synchronous reset also aborts any operation in progress and leaves the target words unchanged.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy_o`, `susp_o`, `spm_o` and `rd_data` are 0, and the block is in read mode: a read returns the array word one cycle after `rd_en`.
- R2: The writes 55h/AAh, AAh/55h, 55h/A0h (address/data) followed by one write A/D program word A to old AND D. `busy_o` is high for exactly PROG_CYC (8) cycles when `vpp_lvl` = 01.
- R3: The writes 55h/AAh, AAh/55h, 55h/80h, 55h/AAh, AAh/55h, then A/30h erase the 16-word sector holding A (sector = A[7:4]) to FFh in ERASE_CYC (32) busy cycles. Other sectors are unchanged.
- R4: A write that breaks an unlock sequence, such as F0h in the command slot or a wrong address, returns the sequencer to idle, and the next write does not program.
- R5: The plane is A[7:6]. While an operation runs, reads to other planes return array data.
- R6: A read of the busy plane returns bit 7 = NOT(target bit 7), where the target is the program data or FFh for an erase. Bit 6 differs between consecutive status reads, and bits 5:0 are 0.
- R7: The data B0h written while an operation runs suspends it. `busy_o` falls, `susp_o` rises and reads return array data. The data 30h then resumes it, and the operation completes after the remaining cycles.
- R8: While an operation is suspended, a program to another sector runs to completion, and `susp_o` stays high throughout. A program to the suspended sector, or any erase, is ignored.
- R9: With `vpp_lvl` = 00, program and erase requests are ignored.
- R10: With `vpp_lvl` = 1x, a program takes PROG_FAST (3) cycles and an erase takes ERASE_FAST (12) cycles.
- R11: The erase prefix of five writes followed by 55h/40h sets `spm_o` only at `vpp_lvl` = 1x.
- R12: With `spm_o` high, each write made while not busy programs its data, command codes included. Writes made while busy are ignored.
- R13: `spm_o` clears on reset or one cycle after `vpp_lvl[1]` falls.
- R14: Reset during an operation clears `busy_o`, and the target word keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts any operation |
| vpp_lvl | input | 2 | Supply level: 00 inhibit, 01 normal, 1x high |
| wr_en | input | 1 | Write event strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read event strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read result, valid the cycle after `rd_en` |
| busy_o | output | 1 | An operation is counting down |
| susp_o | output | 1 | An operation is on hold |
| spm_o | output | 1 | Single-pulse program mode active |

## Verification
Programs are issued with directed and random data on words that are already partly cleared, so that an AND result can be told apart from a plain overwrite. Busy-cycle counts are measured at both supply levels to separate the normal timers from the shortened ones. Broken unlock sequences, command codes sent in single-pulse mode, and programs or erases aimed at the suspended sector each show at the ports whether a write was dropped or committed. Reads of the busy plane and of the other planes during the same operation separate status polling from concurrent array reads.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int DATA_W = 8;

    // unlock address/data pairs and command codes
    localparam logic [7:0] UL_ADDR_A = 8'h55;
    localparam logic [7:0] UL_ADDR_B = 8'hAA;
    localparam logic [7:0] UL_KEY_A  = 8'hAA;
    localparam logic [7:0] UL_KEY_B  = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ESET  = 8'h80;
    localparam logic [7:0] CMD_ERASE = 8'h30;
    localparam logic [7:0] CMD_RESUM = 8'h30;
    localparam logic [7:0] CMD_SUSP  = 8'hB0;
    localparam logic [7:0] CMD_SPM   = 8'h40;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_UL1,
        DS_UL2,
        DS_PDATA,
        DS_EUL1,
        DS_EUL2,
        DS_EUL3
    } dec_st_e;

    typedef struct packed {
        logic prog;
        logic erase;
        logic susp;
        logic resume;
        logic spm;
    } dec_ev_t;

    function automatic logic vpp_enabled(input logic [1:0] lvl);
        return lvl != 2'b00;
    endfunction

    function automatic logic vpp_high(input logic [1:0] lvl);
        return lvl[1];
    endfunction

    function automatic logic [DATA_W-1:0] poll_word(input logic tgt7, input logic tog);
        return {~tgt7, tog, {(DATA_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output dec_ev_t           ev
);

    dec_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        ev   = '0;
        if (wr_en && !clr) begin
            case (st_q)
                DS_IDLE: begin
                    if (wr_addr == UL_ADDR_A && wr_data == UL_KEY_A) st_d = DS_UL1;
                    else if (wr_data == CMD_SUSP)                    ev.susp = 1'b1;
                    else if (wr_data == CMD_RESUM)                   ev.resume = 1'b1;
                end
                DS_UL1:
                    st_d = (wr_addr == UL_ADDR_B && wr_data == UL_KEY_B) ? DS_UL2 : DS_IDLE;
                DS_UL2: begin
                    if (wr_addr == UL_ADDR_A && wr_data == CMD_PROG)      st_d = DS_PDATA;
                    else if (wr_addr == UL_ADDR_A && wr_data == CMD_ESET) st_d = DS_EUL1;
                    else                                                  st_d = DS_IDLE;
                end
                DS_PDATA: begin
                    ev.prog = 1'b1;
                    st_d    = DS_IDLE;
                end
                DS_EUL1:
                    st_d = (wr_addr == UL_ADDR_A && wr_data == UL_KEY_A) ? DS_EUL2 : DS_IDLE;
                DS_EUL2:
                    st_d = (wr_addr == UL_ADDR_B && wr_data == UL_KEY_B) ? DS_EUL3 : DS_IDLE;
                DS_EUL3: begin
                    if (wr_data == CMD_ERASE)                            ev.erase = 1'b1;
                    else if (wr_addr == UL_ADDR_A && wr_data == CMD_SPM) ev.spm = 1'b1;
                    st_d = DS_IDLE;
                end
                default: st_d = DS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) st_q <= DS_IDLE;
        else            st_q <= st_d;
    end

    // R4: a broken unlock pair sends the decoder back to idle
    a_r4_broken_unlock: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr && st_q == DS_UL1 && !(wr_addr == UL_ADDR_B && wr_data == UL_KEY_B))
        |=> st_q == DS_IDLE);

    // R12: single-pulse mode holds the decoder idle
    a_r12_dec_held: assert property (@(posedge clk) disable iff (rst)
        clr |=> st_q == DS_IDLE);

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    input  logic          run,
    output logic          active,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    assign active = cnt_q != '0;
    assign done   = run && !load && cnt_q == CW'(1);

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (load)              cnt_q <= len;
        else if (run && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end

    // R7: a held timer keeps its remaining count
    a_r7_hold_count: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q));

    // R2: completion empties the timer
    a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> !active);

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int AW = 8,
    parameter int SW = 4
) (
    input  logic              clk,
    input  logic              pgm_en,
    input  logic [AW-1:0]     pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              ers_en,
    input  logic [AW-SW-1:0]  ers_sec,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << AW;
    localparam int SECT  = 1 << SW;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_word = mem[rd_addr];

    // contents survive reset, as a nonvolatile array does
    always_ff @(posedge clk) begin
        if (ers_en) begin
            for (int i = 0; i < SECT; i++)
                mem[{ers_sec, SW'(i)}] <= '1;
        end else if (pgm_en) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int AW         = 8,
    parameter int SW         = 4,
    parameter int NPLANE     = 4,
    parameter int PROG_CYC   = 8,
    parameter int ERASE_CYC  = 32,
    parameter int PROG_FAST  = 3,
    parameter int ERASE_FAST = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        vpp_lvl,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy_o,
    output logic              susp_o,
    output logic              spm_o
);

    localparam int PLW = $clog2(NPLANE);
    localparam int CW  = $clog2(ERASE_CYC + 1);

    typedef struct packed {
        logic              is_erase;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] data;
    } op_t;

    dec_ev_t ev;
    op_t     prim_q, nest_q, cur_op;
    logic    spm_q, susp_q, tog_q;
    logic    prim_act, prim_done, nest_act, nest_done;
    logic    vpp_ok, vpp_hi, req_prog, start_prim, start_nest;
    logic    status_hit;
    logic [CW-1:0]     prog_len, prim_len;
    logic [DATA_W-1:0] arr_word;

    fcs_decoder i_dec (
        .clk     (clk),
        .rst     (rst),
        .clr     (spm_q),
        .wr_en   (wr_en),
        .wr_addr (wr_addr[7:0]),
        .wr_data (wr_data),
        .ev      (ev)
    );

    assign vpp_ok   = vpp_enabled(vpp_lvl);
    assign vpp_hi   = vpp_high(vpp_lvl);
    assign prog_len = vpp_hi ? CW'(PROG_FAST) : CW'(PROG_CYC);
    assign prim_len = ev.erase ? (vpp_hi ? CW'(ERASE_FAST) : CW'(ERASE_CYC)) : prog_len;
    assign busy_o   = (prim_act && !susp_q) || nest_act;

    // single-pulse mode turns every idle write into a program request
    assign req_prog   = spm_q ? (wr_en && !busy_o) : ev.prog;
    assign start_prim = vpp_ok && !prim_act && (req_prog || ev.erase);
    assign start_nest = vpp_ok && req_prog && prim_act && susp_q && !nest_act &&
                        (wr_addr[AW-1:SW] != prim_q.addr[AW-1:SW]);

    fcs_timer #(.CW(CW)) i_prim_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (start_prim),
        .len    (prim_len),
        .run    (prim_act && !susp_q),
        .active (prim_act),
        .done   (prim_done)
    );

    fcs_timer #(.CW(CW)) i_nest_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (start_nest),
        .len    (prog_len),
        .run    (nest_act),
        .active (nest_act),
        .done   (nest_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            nest_q <= '0;
            susp_q <= 1'b0;
            spm_q  <= 1'b0;
        end else begin
            if (start_prim) prim_q <= '{is_erase: ev.erase, addr: wr_addr, data: wr_data};
            if (start_nest) nest_q <= '{is_erase: 1'b0, addr: wr_addr, data: wr_data};

            if (prim_done)
                susp_q <= 1'b0;
            else if (ev.susp && prim_act && !susp_q)
                susp_q <= 1'b1;
            else if (ev.resume && susp_q && !nest_act)
                susp_q <= 1'b0;

            if (!vpp_hi)
                spm_q <= 1'b0;
            else if (ev.spm && !prim_act)
                spm_q <= 1'b1;
        end
    end

    fcs_array #(.AW(AW), .SW(SW)) i_arr (
        .clk      (clk),
        .pgm_en   ((prim_done && !prim_q.is_erase) || nest_done),
        .pgm_addr (nest_done ? nest_q.addr : prim_q.addr),
        .pgm_data (nest_done ? nest_q.data : prim_q.data),
        .ers_en   (prim_done && prim_q.is_erase),
        .ers_sec  (prim_q.addr[AW-1:SW]),
        .rd_addr  (rd_addr),
        .rd_word  (arr_word)
    );

    assign cur_op     = nest_act ? nest_q : prim_q;
    assign status_hit = busy_o && (rd_addr[AW-1 -: PLW] == cur_op.addr[AW-1 -: PLW]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else if (rd_en) begin
            if (status_hit) begin
                rd_data <= poll_word(cur_op.is_erase | cur_op.data[DATA_W-1], tog_q);
                tog_q   <= ~tog_q;
            end else begin
                rd_data <= arr_word;
            end
        end
    end

    assign susp_o = susp_q;
    assign spm_o  = spm_q;

    // R1: reset leaves the block idle in read mode
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy_o && !susp_o && !spm_o));

    // R8: a nested program only exists under a suspended operation
    a_r8_nest_under_susp: assert property (@(posedge clk) disable iff (rst)
        nest_act |-> susp_q);

    // R9: nothing starts at the inhibit level
    a_r9_inhibit: assert property (@(posedge clk) disable iff (rst)
        (vpp_lvl == 2'b00 && !busy_o && !susp_o) |=> !busy_o);

    // R13: single-pulse mode ends when the supply leaves high
    a_r13_spm_exit: assert property (@(posedge clk) disable iff (rst)
        (spm_o && !vpp_lvl[1]) |=> !spm_o);

    // R12: no command events reach the sequencer in single-pulse mode
    a_r12_no_cmds: assert property (@(posedge clk) disable iff (rst)
        spm_q |-> !(ev.susp || ev.resume || ev.erase || ev.spm));

    // R6: erase status reads show bit 7 low
    a_r6_erase_poll: assert property (@(posedge clk) disable iff (rst)
        (rd_en && status_hit && cur_op.is_erase) |=> !rd_data[DATA_W-1]);

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

    localparam int PROG_CYC = 8, ERASE_CYC = 32, PROG_FAST = 3, ERASE_FAST = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] vpp_lvl = 2'b01;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy_o, susp_o, spm_o;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0;
    logic [7:0] mdl [256];

    always #5 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst(rst), .vpp_lvl(vpp_lvl),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy_o(busy_o), .susp_o(susp_o), .spm_o(spm_o)
    );

    function automatic logic [7:0] f_prog(input logic [7:0] old_w, input logic [7:0] d);
        return old_w & d;
    endfunction

    function automatic int f_len(input logic [1:0] lvl, input bit erase);
        if (lvl[1]) return erase ? ERASE_FAST : PROG_FAST;
        return erase ? ERASE_CYC : PROG_CYC;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tasks are entered at a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] q);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic unlock(input logic [7:0] cmd);
        wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, cmd);
    endtask

    task automatic prog(input logic [7:0] a, input logic [7:0] d);
        unlock(8'hA0); wr(a, d);
    endtask

    task automatic erase_tail(input logic [7:0] a, input logic [7:0] last);
        unlock(8'h80); wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(a, last);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic chk_word(input string tag, input logic [7:0] a);
        logic [7:0] q;
        rd(a, q);
        check(tag, q, mdl[a]);
    endtask

    task automatic pulse_reset;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int n;
        logic [7:0] q, q2;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 busy", busy_o, 0);
        check("R1 susp", susp_o, 0);
        check("R1 spm", spm_o, 0);
        check("R1 rd_data", rd_data, 0);

        // R10: erase every sector at high supply
        vpp_lvl = 2'b10;
        for (int s = 0; s < 16; s++) begin
            erase_tail(8'(s * 16), 8'h30);
            wait_idle(n);
            check("R10 erase length", n, ERASE_FAST);
            for (int w = 0; w < 16; w++) mdl[s * 16 + w] = 8'hFF;
        end
        chk_word("R3 erased word", 8'h73);
        chk_word("R1 read mode", 8'hE9);

        // R2: program and AND behaviour at normal supply
        vpp_lvl = 2'b01;
        prog(8'h13, 8'h5A);
        wait_idle(n);
        check("R2 program length", n, PROG_CYC);
        mdl[8'h13] = 8'h5A;
        chk_word("R2 program data", 8'h13);
        prog(8'h13, 8'hF0);
        wait_idle(n);
        mdl[8'h13] = f_prog(mdl[8'h13], 8'hF0);
        chk_word("R2 and with old", 8'h13);

        // R3: sector erase leaves neighbours alone
        prog(8'h2F, 8'h11); wait_idle(n); mdl[8'h2F] = 8'h11;
        erase_tail(8'h10, 8'h30);
        wait_idle(n);
        check("R3 erase length", n, ERASE_CYC);
        for (int w = 0; w < 16; w++) mdl[8'h10 + w] = 8'hFF;
        chk_word("R3 sector word", 8'h13);
        chk_word("R3 other sector", 8'h2F);

        // R4: broken sequences do not program
        wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hF0); wr(8'h14, 8'h00);
        check("R4 read-reset no busy", busy_o, 0);
        chk_word("R4 read-reset word", 8'h14);
        wr(8'h55, 8'hAA); wr(8'hAB, 8'h55); wr(8'h55, 8'hA0); wr(8'h15, 8'h00);
        check("R4 wrong addr no busy", busy_o, 0);
        chk_word("R4 wrong addr word", 8'h15);

        // R5 / R6: concurrent reads and polling
        prog(8'h40, 8'h5A);
        chk_word("R5 other plane read", 8'h13);
        rd(8'h41, q);
        rd(8'h7E, q2);
        check("R6 bit7 program", q[7], 1);
        check("R6 low bits", q[5:0], 0);
        check("R6 toggle", q[6] != q2[6], 1);
        wait_idle(n);
        mdl[8'h40] = 8'h5A;
        chk_word("R6 program done", 8'h40);
        erase_tail(8'hC0, 8'h30);
        rd(8'hC5, q);
        check("R6 bit7 erase", q[7], 0);
        chk_word("R5 read during erase", 8'h2F);
        wait_idle(n);

        // R7: suspend and resume a program
        prog(8'h81, 8'h3C);
        wr(8'h00, 8'hB0);
        check("R7 busy drops", busy_o, 0);
        check("R7 susp set", susp_o, 1);
        chk_word("R7 array read while held", 8'h81);
        repeat (5) @(negedge clk);
        check("R7 still held", busy_o, 0);
        wr(8'h00, 8'h30);
        wait_idle(n);
        check("R7 remaining cycles", n, PROG_CYC - 1);
        check("R7 susp clear", susp_o, 0);
        mdl[8'h81] = 8'h3C;
        chk_word("R7 program result", 8'h81);

        // R8: work during an erase suspend
        prog(8'h61, 8'h12); wait_idle(n); mdl[8'h61] = 8'h12;
        erase_tail(8'h30, 8'h30);
        wr(8'h00, 8'hB0);
        prog(8'h05, 8'h77);
        wait_idle(n);
        check("R8 nested length", n, PROG_CYC);
        check("R8 still suspended", susp_o, 1);
        mdl[8'h05] = 8'h77;
        chk_word("R8 nested data", 8'h05);
        prog(8'h32, 8'h00);
        check("R8 same sector ignored", busy_o, 0);
        erase_tail(8'h60, 8'h30);
        check("R8 erase ignored", busy_o, 0);
        wr(8'h00, 8'h30);
        wait_idle(n);
        for (int w = 0; w < 16; w++) mdl[8'h30 + w] = 8'hFF;
        chk_word("R8 suspended sector", 8'h32);
        chk_word("R8 erase left sector", 8'h61);

        // R9: inhibit level
        vpp_lvl = 2'b00;
        prog(8'h50, 8'h00);
        check("R9 program ignored", busy_o, 0);
        erase_tail(8'h60, 8'h30);
        check("R9 erase ignored", busy_o, 0);
        vpp_lvl = 2'b01;
        chk_word("R9 word kept", 8'h50);
        chk_word("R9 sector kept", 8'h61);

        // R11: entry code needs the high level
        erase_tail(8'h55, 8'h40);
        check("R11 no entry at normal", spm_o, 0);
        vpp_lvl = 2'b10;
        erase_tail(8'h55, 8'h40);
        check("R11 entry at high", spm_o, 1);

        // R12: single-pulse programs
        wr(8'h90, 8'hB0);
        wait_idle(n);
        check("R12 fast program", n, PROG_FAST);
        mdl[8'h90] = 8'hB0;
        chk_word("R12 suspend code as data", 8'h90);
        wr(8'h91, 8'hF0);
        wr(8'h92, 8'h00);
        wait_idle(n);
        mdl[8'h91] = 8'hF0;
        chk_word("R12 pulse data", 8'h91);
        chk_word("R12 busy write ignored", 8'h92);
        wr(8'h55, 8'hAA); wait_idle(n);
        mdl[8'h55] = 8'hAA;
        chk_word("R12 unlock code as data", 8'h55);

        // R13: exits
        vpp_lvl = 2'b01;
        @(negedge clk);
        check("R13 exit on supply drop", spm_o, 0);
        vpp_lvl = 2'b11;
        erase_tail(8'h55, 8'h40);
        check("R11 entry at 11", spm_o, 1);
        pulse_reset;
        check("R13 exit on reset", spm_o, 0);

        // R14: reset aborts
        vpp_lvl = 2'b01;
        prog(8'hA0, 8'h00);
        repeat (3) @(negedge clk);
        pulse_reset;
        check("R14 busy cleared", busy_o, 0);
        chk_word("R14 word unchanged", 8'hA0);

        // random programs with concurrent reads
        for (int k = 0; k < 40; k++) begin
            logic [7:0] a, d, o;
            logic [1:0] lv;
            a  = 8'($urandom);
            d  = 8'($urandom);
            lv = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
            o  = {~a[7], a[6:0]};
            vpp_lvl = lv;
            prog(a, d);
            chk_word("R5 random other plane", o);
            wait_idle(n);
            check("R2 random length", n, f_len(lv, 1'b0) - 1);
            mdl[a] = f_prog(mdl[a], d);
            chk_word("R2 random data", a);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule